// File: doc/BRIEF.md
# MAC Statistics and Interrupt Unit

This block keeps the traffic statistics of an Ethernet MAC and turns notable events into a maskable interrupt. The transmit and receive data paths each present a one-cycle event pulse per finished frame. The pulse carries the frame length in bytes, and on the receive side it also carries classification flags: dropped, CRC error, pause, broadcast and multicast. Ten saturating counters accumulate these events. Two status registers record when a frame completes and when any counter runs past its limit.

Software reaches the unit through a flat register port. A write is a single-cycle strobe. A read returns data one cycle after the address is presented. Through this port software enables each direction, masks individual status bits, clears them with write-one, forces them through mirror registers and resets either direction. The interrupt output is a registered OR of all unmasked status bits.

Top module: `mac_stat_irq`

## Requirements
- R1: Each counter is CNT_W bits wide (default 32). An increment that would pass all ones leaves the counter at all ones, and it stays there until a soft reset of its direction.
- R2: A counter's overflow status bit is set by the event whose increment would carry past all ones. An event landing exactly on all ones does not set it. Once set, the bit stays set until it is cleared.
- R3: Transmit counters do not change while transmit is disabled (tx config bit 0 = 0). Receive counters do not change while receive is disabled (rx config bit 0 = 0).
- R4: Each transmit event adds 1 to the tx frame counter (0x100) and its length to the tx byte counter (0x108). Each receive event adds 1 and its length to the rx frame (0x110) and rx byte (0x118) counters, whatever its flags. Flagged receive events also count in the following counters: dropped frames 0x120, dropped bytes 0x128 (adds the length), CRC errors 0x130, pause 0x138, broadcast 0x140, multicast 0x148.
- R5: Tx status (0x20) bit 0 is frame sent, bit 1 is tx frame counter overflow, and bit 2 is tx byte counter overflow.
- R6: Rx status (0x30) bits 0..8 are:
  - bit 0: frame received without the drop flag
  - bit 1: frame counter overflow
  - bit 2: byte counter overflow
  - bit 3: dropped frame counter overflow
  - bit 4: dropped byte counter overflow
  - bit 5: CRC counter overflow
  - bit 6: pause counter overflow
  - bit 7: multicast counter overflow
  - bit 8: broadcast counter overflow
- R7: Writing 1 to a status bit clears it. The mirror reads back the cleared value. A set event in the same cycle wins over the clear.
- R8: Writing 1 to a bit of the tx mirror (0x40) or the rx mirror (0x48) sets that status bit, even when the direction is disabled. Reading a mirror returns the current status.
- R9: The irq output is high one cycle after any status bit is 1 while its mask bit is 0. The tx mask is at 0x28 and the rx mask at 0x38. A mask bit of 1 suppresses its status bit.
- R10: Events arriving while their direction is disabled set no status bit. Disabling a direction leaves its existing status bits unchanged.
- R11: reg_rdata presents the register at the address of the previous cycle. Reads change no state. After reset all registers read 0 and irq is 0.
- R12: Writing 1 to bit 0 of 0x00 clears the transmit counters and tx status. Writing 1 to bit 8 clears the receive counters and rx status. The other direction is untouched. 0x00 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| tx_evt | input | 1 | One-cycle pulse per transmitted frame |
| tx_len | input | LEN_W | Bytes of that transmitted frame, header to pad |
| rx_evt | input | 1 | One-cycle pulse per received frame |
| rx_len | input | LEN_W | Bytes of that received frame |
| rx_drop | input | 1 | Received frame was dropped |
| rx_crc_err | input | 1 | Received frame had a CRC error |
| rx_pause | input | 1 | Received frame was a pause frame |
| rx_bcast | input | 1 | Received frame was broadcast |
| rx_mcast | input | 1 | Received frame was multicast |
| irq | output | 1 | Registered interrupt request |

## Verification
The receive side is driven with a table of frames. Each entry combines the classification flags differently (plain, dropped with CRC error, dropped pause, broadcast, multicast), so a flag routed to the wrong counter shows up as a mismatch in exactly one total. The transmit byte counter is walked up to its limit with a reduced width, in three steps: an increment that stays below the limit, one that lands exactly on it, and one that passes it. This separates saturation from wrapping and shows whether the overflow status comes one event too early. Further directed sequences check three more behaviours:
- events arriving while a direction is disabled change nothing
- forced bits read back through both the status and the mirror address
- a soft reset of one direction leaves the other intact

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  // register byte offsets
  localparam int OFS_SRST  = 'h000;
  localparam int OFS_TXCFG = 'h008;
  localparam int OFS_RXCFG = 'h010;
  localparam int OFS_TXST  = 'h020;
  localparam int OFS_TXMSK = 'h028;
  localparam int OFS_RXST  = 'h030;
  localparam int OFS_RXMSK = 'h038;
  localparam int OFS_TXMIR = 'h040;
  localparam int OFS_RXMIR = 'h048;
  localparam int OFS_CNT0  = 'h100;
  localparam int CNT_STEP  = 8;

  // soft reset command bits
  localparam int SRST_TX_BIT = 0;
  localparam int SRST_RX_BIT = 8;

  localparam int TX_ST_W = 3;
  localparam int RX_ST_W = 9;

  // counter slots, in address order
  localparam int CI_TXFR  = 0;
  localparam int CI_TXBY  = 1;
  localparam int CI_RXFR  = 2;
  localparam int CI_RXBY  = 3;
  localparam int CI_DRFR  = 4;
  localparam int CI_DRBY  = 5;
  localparam int CI_CRC   = 6;
  localparam int CI_PAUSE = 7;
  localparam int CI_BCAST = 8;
  localparam int CI_MCAST = 9;
  localparam int NUM_CNT  = 10;
  localparam int NUM_TX_CNT = 2;
endpackage

// File: rtl/mstat_sat_counter.sv
module mstat_sat_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             hit,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'({CNT_W{1'b1}});

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(count) + SUM_W'(inc);
    ovf = en && hit && (sum > LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (en && hit) begin
      count <= ovf ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/mstat_status.sv
module mstat_status #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] force_bits,
  input  logic [W-1:0] clear_bits,
  output logic [W-1:0] stat
);
  // a set or force in the same cycle as a clear keeps the bit
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      stat <= '0;
    end else begin
      stat <= (stat & ~clear_bits) | set_bits | force_bits;
    end
  end
endmodule

// File: rtl/mac_stat_irq.sv
module mac_stat_irq
  import mstat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_evt,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              rx_evt,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_drop,
  input  logic              rx_crc_err,
  input  logic              rx_pause,
  input  logic              rx_bcast,
  input  logic              rx_mcast,
  output logic              irq
);
  logic               tx_en_q, rx_en_q;
  logic [TX_ST_W-1:0] tx_msk_q, tx_stat, tx_set, tx_force, tx_clear;
  logic [RX_ST_W-1:0] rx_msk_q, rx_stat, rx_set, rx_force, rx_clear;
  logic               tx_srst, rx_srst;

  logic [NUM_CNT-1:0]            c_hit, c_ovf;
  logic [NUM_CNT-1:0][LEN_W-1:0] c_inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] c_val;

  function automatic logic wr_at(input int ofs);
    return reg_wr && (reg_addr == ADDR_W'(ofs));
  endfunction

  assign tx_srst = wr_at(OFS_SRST) && reg_wdata[SRST_TX_BIT];
  assign rx_srst = wr_at(OFS_SRST) && reg_wdata[SRST_RX_BIT];

  // configuration and mask registers
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      tx_msk_q <= '0;
      rx_msk_q <= '0;
    end else begin
      if (wr_at(OFS_TXCFG)) tx_en_q  <= reg_wdata[0];
      if (wr_at(OFS_RXCFG)) rx_en_q  <= reg_wdata[0];
      if (wr_at(OFS_TXMSK)) tx_msk_q <= reg_wdata[TX_ST_W-1:0];
      if (wr_at(OFS_RXMSK)) rx_msk_q <= reg_wdata[RX_ST_W-1:0];
    end
  end

  // event routing to counter slots
  always_comb begin
    c_hit = '0;
    c_inc = '0;
    c_hit[CI_TXFR]  = tx_evt;             c_inc[CI_TXFR]  = LEN_W'(1);
    c_hit[CI_TXBY]  = tx_evt;             c_inc[CI_TXBY]  = tx_len;
    c_hit[CI_RXFR]  = rx_evt;             c_inc[CI_RXFR]  = LEN_W'(1);
    c_hit[CI_RXBY]  = rx_evt;             c_inc[CI_RXBY]  = rx_len;
    c_hit[CI_DRFR]  = rx_evt && rx_drop;  c_inc[CI_DRFR]  = LEN_W'(1);
    c_hit[CI_DRBY]  = rx_evt && rx_drop;  c_inc[CI_DRBY]  = rx_len;
    c_hit[CI_CRC]   = rx_evt && rx_crc_err; c_inc[CI_CRC] = LEN_W'(1);
    c_hit[CI_PAUSE] = rx_evt && rx_pause; c_inc[CI_PAUSE] = LEN_W'(1);
    c_hit[CI_BCAST] = rx_evt && rx_bcast; c_inc[CI_BCAST] = LEN_W'(1);
    c_hit[CI_MCAST] = rx_evt && rx_mcast; c_inc[CI_MCAST] = LEN_W'(1);
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam bit IS_TX = (i < NUM_TX_CNT);
    mstat_sat_counter #(.CNT_W(CNT_W), .INC_W(LEN_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (IS_TX ? tx_srst : rx_srst),
      .en    (IS_TX ? tx_en_q : rx_en_q),
      .hit   (c_hit[i]),
      .inc   (c_inc[i]),
      .count (c_val[i]),
      .ovf   (c_ovf[i])
    );
  end

  // status sources; rx bit order is fixed by the register layout
  always_comb begin
    tx_set   = {c_ovf[CI_TXBY], c_ovf[CI_TXFR], tx_evt && tx_en_q};
    rx_set   = {c_ovf[CI_BCAST], c_ovf[CI_MCAST], c_ovf[CI_PAUSE],
                c_ovf[CI_CRC], c_ovf[CI_DRBY], c_ovf[CI_DRFR],
                c_ovf[CI_RXBY], c_ovf[CI_RXFR], rx_evt && !rx_drop && rx_en_q};
    tx_force = wr_at(OFS_TXMIR) ? reg_wdata[TX_ST_W-1:0] : '0;
    rx_force = wr_at(OFS_RXMIR) ? reg_wdata[RX_ST_W-1:0] : '0;
    tx_clear = wr_at(OFS_TXST)  ? reg_wdata[TX_ST_W-1:0] : '0;
    rx_clear = wr_at(OFS_RXST)  ? reg_wdata[RX_ST_W-1:0] : '0;
  end

  mstat_status #(.W(TX_ST_W)) u_txst (
    .clk(clk), .rst(rst), .clr_all(tx_srst), .set_bits(tx_set),
    .force_bits(tx_force), .clear_bits(tx_clear), .stat(tx_stat));

  mstat_status #(.W(RX_ST_W)) u_rxst (
    .clk(clk), .rst(rst), .clr_all(rx_srst), .set_bits(rx_set),
    .force_bits(rx_force), .clear_bits(rx_clear), .stat(rx_stat));

  // registered read mux
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFS_TXCFG)) rd_mux = DATA_W'(tx_en_q);
    if (reg_addr == ADDR_W'(OFS_RXCFG)) rd_mux = DATA_W'(rx_en_q);
    if (reg_addr == ADDR_W'(OFS_TXMSK)) rd_mux = DATA_W'(tx_msk_q);
    if (reg_addr == ADDR_W'(OFS_RXMSK)) rd_mux = DATA_W'(rx_msk_q);
    if (reg_addr == ADDR_W'(OFS_TXST) || reg_addr == ADDR_W'(OFS_TXMIR))
      rd_mux = DATA_W'(tx_stat);
    if (reg_addr == ADDR_W'(OFS_RXST) || reg_addr == ADDR_W'(OFS_RXMIR))
      rd_mux = DATA_W'(rx_stat);
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == ADDR_W'(OFS_CNT0 + CNT_STEP * i)) rd_mux = DATA_W'(c_val[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq       <= (|(tx_stat & ~tx_msk_q)) || (|(rx_stat & ~rx_msk_q));
    end
  end
endmodule

// File: rtl/mstat_checker.sv
module mstat_checker
  import mstat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          reg_wr,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [DATA_W-1:0]             reg_wdata,
  input logic                          tx_en_q,
  input logic                          rx_en_q,
  input logic                          tx_srst,
  input logic                          rx_srst,
  input logic [NUM_CNT-1:0][CNT_W-1:0] c_val,
  input logic [TX_ST_W-1:0]            tx_stat,
  input logic [RX_ST_W-1:0]            rx_stat,
  input logic [TX_ST_W-1:0]            tx_msk_q,
  input logic [RX_ST_W-1:0]            rx_msk_q,
  input logic                          irq
);
  logic txmir_wr, txst_wr;
  assign txmir_wr = reg_wr && (reg_addr == ADDR_W'(OFS_TXMIR));
  assign txst_wr  = reg_wr && (reg_addr == ADDR_W'(OFS_TXST));

  assert_sat_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (c_val[CI_TXBY] == {CNT_W{1'b1}} && !tx_srst) |=> c_val[CI_TXBY] == {CNT_W{1'b1}});

  assert_rx_sat_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (c_val[CI_RXBY] == {CNT_W{1'b1}} && !rx_srst) |=> c_val[CI_RXBY] == {CNT_W{1'b1}});

  assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_stat[2] && !tx_srst && !(txst_wr && reg_wdata[2])) |=> tx_stat[2]);

  assert_tx_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (!tx_en_q && !tx_srst) |=> ($stable(c_val[CI_TXFR]) && $stable(c_val[CI_TXBY])));

  assert_rx_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (!rx_en_q && !rx_srst) |=> $stable(c_val[NUM_CNT-1:NUM_TX_CNT]));

  assert_all_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (&tx_msk_q && &rx_msk_q) |=> !irq);

  assert_no_new_status_R10: assert property (@(posedge clk) disable iff (rst)
    (!tx_en_q && !txmir_wr) |=> ((tx_stat & ~$past(tx_stat)) == '0));
endmodule

bind mac_stat_irq mstat_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .tx_en_q(tx_en_q), .rx_en_q(rx_en_q), .tx_srst(tx_srst), .rx_srst(rx_srst),
  .c_val(c_val), .tx_stat(tx_stat), .rx_stat(rx_stat),
  .tx_msk_q(tx_msk_q), .rx_msk_q(rx_msk_q), .irq(irq));

// File: tb/sim_mac_stat_irq.sv
module sim_mac_stat_irq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = 12;
  localparam int LEN_W = 16;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int MAXV = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0, reg_rdata;
  logic tx_evt = 1'b0, rx_evt = 1'b0;
  logic [LEN_W-1:0] tx_len = '0, rx_len = '0;
  logic rx_drop = 0, rx_crc_err = 0, rx_pause = 0, rx_bcast = 0, rx_mcast = 0;
  logic irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mac_stat_irq #(.CNT_W(CNT_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_evt(tx_evt), .tx_len(tx_len), .rx_evt(rx_evt),
    .rx_len(rx_len), .rx_drop(rx_drop), .rx_crc_err(rx_crc_err), .rx_pause(rx_pause),
    .rx_bcast(rx_bcast), .rx_mcast(rx_mcast), .irq(irq));

  // rx frames: {len, drop, crc, pause, bcast, mcast}
  localparam logic [20:0] RXV [6] = '{
    {16'd64,  5'b00000},
    {16'd100, 5'b11000},
    {16'd64,  5'b10100},
    {16'd128, 5'b00010},
    {16'd72,  5'b00001},
    {16'd200, 5'b00010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = ADDR_W'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic tx_send(input int len);
    @(negedge clk);
    tx_evt = 1'b1; tx_len = LEN_W'(len);
    @(negedge clk);
    tx_evt = 1'b0;
  endtask

  task automatic rx_send(input logic [20:0] v);
    @(negedge clk);
    rx_evt = 1'b1; rx_len = v[20:5];
    {rx_drop, rx_crc_err, rx_pause, rx_bcast, rx_mcast} = v[4:0];
    @(negedge clk);
    rx_evt = 1'b0;
    {rx_drop, rx_crc_err, rx_pause, rx_bcast, rx_mcast} = '0;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp_cnt [10];
    logic [31:0] v1, v2;
    foreach (exp_cnt[k]) exp_cnt[k] = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk("R11 irq after reset", 32'(irq), 0);
    rd_chk("R11 tx status reset", 'h20, 0);
    rd_chk("R11 rx status reset", 'h30, 0);
    rd_chk("R11 tx frame cnt reset", 'h100, 0);
    rd_chk("R11 rx byte cnt reset", 'h118, 0);

    // R3/R10 transmit disabled
    tx_send(50);
    rd_chk("R3 tx frames stalled", 'h100, 0);
    rd_chk("R10 no status while disabled", 'h20, 0);

    // R4 receive table
    wr('h10, 1);
    for (int i = 0; i < 6; i++) begin
      logic [20:0] v;
      v = RXV[i];
      rx_send(v);
      exp_cnt[2]++; exp_cnt[3] += int'(v[20:5]);
      if (v[4]) begin exp_cnt[4]++; exp_cnt[5] += int'(v[20:5]); end
      if (v[3]) exp_cnt[6]++;
      if (v[2]) exp_cnt[7]++;
      if (v[1]) exp_cnt[8]++;
      if (v[0]) exp_cnt[9]++;
      rd_chk("R4 rx frames", 'h110, 32'(exp_cnt[2]));
      rd_chk("R4 rx bytes", 'h118, 32'(exp_cnt[3]));
    end
    for (int i = 4; i < 10; i++) rd_chk("R4 rx class counter", 'h100 + 8 * i, 32'(exp_cnt[i]));
    rd_chk("R6 rx status frame bit0", 'h30, 32'h001);
    chk("R9 irq unmasked", 32'(irq), 1);

    // R9 masking
    wr('h38, 32'h1FF);
    @(negedge clk); @(negedge clk);
    chk("R9 irq masked", 32'(irq), 0);
    wr('h38, 0);

    // R7 clear, R8 force
    wr('h30, 32'h001);
    rd_chk("R7 mirror after clear", 'h48, 0);
    wr('h48, 32'h080);
    rd_chk("R8 forced status", 'h30, 32'h080);
    rd_chk("R8 mirror reads status", 'h48, 32'h080);
    wr('h30, 32'h080);
    rd_chk("R7 status cleared", 'h30, 0);

    // R1/R2/R5 transmit saturation
    wr('h08, 1);
    tx_send(60);
    rd_chk("R4 tx frames", 'h100, 1);
    rd_chk("R4 tx bytes", 'h108, 60);
    rd_chk("R5 tx frame sent bit0", 'h20, 32'h1);
    wr('h20, 7);
    tx_send(4000);
    rd_chk("R2 no early overflow", 'h20, 32'h1);
    wr('h20, 7);
    tx_send(35);
    rd_chk("R1 exact limit", 'h108, MAXV);
    rd_chk("R2 landing on limit no overflow", 'h20, 32'h1);
    wr('h20, 7);
    tx_send(1);
    rd_chk("R1 saturated", 'h108, MAXV);
    rd_chk("R5 byte overflow bit2", 'h20, 32'h5);

    // R10/R3 disable keeps status and counters
    wr('h08, 0);
    rd_chk("R10 status kept on disable", 'h20, 32'h5);
    tx_send(10);
    rd_chk("R3 tx frames held", 'h100, 4);
    rd_chk("R10 status unchanged", 'h20, 32'h5);

    // R11 reads are side-effect free
    rd(OFS_RX_BY(), v1);
    rd(OFS_RX_BY(), v2);
    chk("R11 repeat read stable", v2, v1);

    // R12 soft reset of transmit only
    wr('h00, 32'h1);
    rd_chk("R12 tx frames cleared", 'h100, 0);
    rd_chk("R12 tx bytes cleared", 'h108, 0);
    rd_chk("R12 tx status cleared", 'h20, 0);
    rd_chk("R12 reset reg reads 0", 'h00, 0);
    rd_chk("R12 rx untouched", 'h110, 32'(exp_cnt[2]));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int OFS_RX_BY();
    return 'h118;
  endfunction
endmodule